// File: doc/BRIEF.md
# Sync Flood Error Controller

This block decides when a two-sided bridge floods its outgoing links with sync packets to signal a fatal system error. It also keeps the two system-error status bits that software reads. There is one group of outgoing links on the primary side and one on the secondary side. Each link has an input that reports an incoming sync flood seen on it, and an output that asks that link's transmitter to send a flood.

A local fatal error starts a flood on every outgoing link only when the command-register system-error enable is set. Such a flood is an originated flood, and only an originated flood sets the signalled-system-error bit. A flood that arrives on one link is passed on to the other links of the same side whatever the enables are. A flood seen on the secondary side sets the secondary detected-system-error bit. That flood crosses to the primary links only when the bridge-control system-error enable is set.

Every flood request and status bit holds its value until the synchronous reset, which stands for the link reset. While any link is flooding, an access-lock output tells the rest of the device to refuse configuration accesses.

Top module: `sync_flood_ctrl`

## Requirements
- R1: When `local_fatal` and `cmd_sys_err_en` are both 1 at a rising clock edge, every bit of `pri_flood_req` and `sec_flood_req` is 1 after that edge.
- R2: When `cmd_sys_err_en` is 0, a `local_fatal` pulse changes no output. Setting the enable in a later cycle does not start a flood for that earlier pulse.
- R3: A 1 on bit i of `pri_flood_seen` (or `sec_flood_seen`) sets every other bit j≠i of `pri_flood_req` (or `sec_flood_req`) after the edge. Neither enable affects this. Bit i itself is not set by its own detection.
- R4: `sig_sys_err` becomes 1 only after an edge where R1's condition held. A relayed or bridged flood never sets it.
- R5: Any 1 on `sec_flood_seen` sets `sec_det_sys_err` after the edge, whatever the enables are.
- R6: Any 1 on `sec_flood_seen` while `bctl_sys_err_en` is 1 sets every bit of `pri_flood_req` after the edge. When `bctl_sys_err_en` is 0, a secondary flood leaves `pri_flood_req` unchanged.
- R7: Flood requests and status bits are sticky: once set, each stays 1 until reset. `access_lock` is 1 from the edge where any flood request first becomes 1 until reset.
- R8: A clock edge with `rst` = 1 clears all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high link reset |
| local_fatal | input | 1 | Single-cycle local error event programmed as fatal |
| cmd_sys_err_en | input | 1 | Command-register system-error enable |
| bctl_sys_err_en | input | 1 | Bridge-control system-error enable (secondary to primary) |
| pri_flood_seen | input | NP | Incoming flood detected, one bit per primary link |
| sec_flood_seen | input | NS | Incoming flood detected, one bit per secondary link |
| pri_flood_req | output | NP | Flood request, one bit per primary outgoing link |
| sec_flood_req | output | NS | Flood request, one bit per secondary outgoing link |
| sig_sys_err | output | 1 | Signalled-system-error status (this device originated a flood) |
| sec_det_sys_err | output | 1 | Secondary detected-system-error status |
| access_lock | output | 1 | Device is flooding; accesses refused until reset |

## Verification
The assertions assume every input is a defined 0 or 1 at each edge once reset is released. They also assume the enables hold their value through each edge where an event occurs. This is because each property relates a single-cycle event at one edge to the outputs at the next. The bench drives all inputs at the falling edge and resets the block between unrelated vectors. Each trigger therefore meets a known, cleared state.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

  typedef struct packed {
    logic sig_err;
    logic det_err;
    logic lock;
  } sfc_status_t;

  localparam sfc_status_t SFC_STATUS_CLEAR = '{sig_err: 1'b0, det_err: 1'b0, lock: 1'b0};

endpackage

// File: rtl/sfc_side_relay.sv
module sfc_side_relay #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] flood_seen,
  input  logic         force_all,
  output logic [N-1:0] flood_req,
  output logic [N-1:0] flood_next
);
  localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] req_q;

  for (genvar gi = 0; gi < N; gi++) begin : g_link
    logic others;
    assign others = |(flood_seen & ~(ONE << gi));
    assign flood_next[gi] = req_q[gi] | force_all | others;

    always_ff @(posedge clk) begin
      if (rst) req_q[gi] <= 1'b0;
      else     req_q[gi] <= flood_next[gi];
    end
  end

  assign flood_req = req_q;
endmodule

// File: rtl/sfc_status.sv
module sfc_status
  import sfc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        set_sig,
  input  logic        set_det,
  input  logic        set_lock,
  output sfc_status_t status
);
  sfc_status_t st_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= SFC_STATUS_CLEAR;
    end else begin
      st_q.sig_err <= st_q.sig_err | set_sig;
      st_q.det_err <= st_q.det_err | set_det;
      st_q.lock    <= st_q.lock    | set_lock;
    end
  end

  assign status = st_q;
endmodule

// File: rtl/sync_flood_ctrl.sv
module sync_flood_ctrl
  import sfc_pkg::*;
#(
  parameter int NP = 2,
  parameter int NS = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          local_fatal,
  input  logic          cmd_sys_err_en,
  input  logic          bctl_sys_err_en,
  input  logic [NP-1:0] pri_flood_seen,
  input  logic [NS-1:0] sec_flood_seen,
  output logic [NP-1:0] pri_flood_req,
  output logic [NS-1:0] sec_flood_req,
  output logic          sig_sys_err,
  output logic          sec_det_sys_err,
  output logic          access_lock
);
  logic        originate;
  logic        sec_seen_any;
  logic        bridge_up;
  logic [NP-1:0] pri_next;
  logic [NS-1:0] sec_next;
  sfc_status_t status;

  assign originate    = local_fatal & cmd_sys_err_en;
  assign sec_seen_any = |sec_flood_seen;
  assign bridge_up    = sec_seen_any & bctl_sys_err_en;

  sfc_side_relay #(.N(NP)) u_pri (
    .clk        (clk),
    .rst        (rst),
    .flood_seen (pri_flood_seen),
    .force_all  (originate | bridge_up),
    .flood_req  (pri_flood_req),
    .flood_next (pri_next)
  );

  sfc_side_relay #(.N(NS)) u_sec (
    .clk        (clk),
    .rst        (rst),
    .flood_seen (sec_flood_seen),
    .force_all  (originate),
    .flood_req  (sec_flood_req),
    .flood_next (sec_next)
  );

  sfc_status u_status (
    .clk      (clk),
    .rst      (rst),
    .set_sig  (originate),
    .set_det  (sec_seen_any),
    .set_lock ((|pri_next) | (|sec_next)),
    .status   (status)
  );

  assign sig_sys_err     = status.sig_err;
  assign sec_det_sys_err = status.det_err;
  assign access_lock     = status.lock;
endmodule

// File: rtl/sfc_checker.sv
module sfc_checker #(
  parameter int NP = 2,
  parameter int NS = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          local_fatal,
  input logic          cmd_sys_err_en,
  input logic          bctl_sys_err_en,
  input logic [NP-1:0] pri_flood_seen,
  input logic [NS-1:0] sec_flood_seen,
  input logic [NP-1:0] pri_flood_req,
  input logic [NS-1:0] sec_flood_req,
  input logic          sig_sys_err,
  input logic          sec_det_sys_err,
  input logic          access_lock
);
  AST_ORIG_FLOODS_ALL: assert property (@(posedge clk) disable iff (rst)
    (local_fatal && cmd_sys_err_en) |=> ((&pri_flood_req) && (&sec_flood_req))); // R1

  AST_SIG_ONLY_ORIGIN: assert property (@(posedge clk) disable iff (rst)
    $rose(sig_sys_err) |-> $past(local_fatal && cmd_sys_err_en)); // R4

  AST_SEC_DETECT: assert property (@(posedge clk) disable iff (rst)
    (|sec_flood_seen) |=> sec_det_sys_err); // R5

  AST_BRIDGE_UP: assert property (@(posedge clk) disable iff (rst)
    ((|sec_flood_seen) && bctl_sys_err_en) |=> (&pri_flood_req)); // R6

  AST_PRI_STICKY: assert property (@(posedge clk) disable iff (rst)
    (|pri_flood_req) |=> ((pri_flood_req & $past(pri_flood_req)) == $past(pri_flood_req))); // R7

  AST_LOCK_COVERS: assert property (@(posedge clk) disable iff (rst)
    ((|pri_flood_req) || (|sec_flood_req)) |-> access_lock); // R7

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!sig_sys_err && !sec_det_sys_err && !access_lock)); // R8
endmodule

bind sync_flood_ctrl sfc_checker #(.NP(NP), .NS(NS)) u_sfc_checker (
  .clk             (clk),
  .rst             (rst),
  .local_fatal     (local_fatal),
  .cmd_sys_err_en  (cmd_sys_err_en),
  .bctl_sys_err_en (bctl_sys_err_en),
  .pri_flood_seen  (pri_flood_seen),
  .sec_flood_seen  (sec_flood_seen),
  .pri_flood_req   (pri_flood_req),
  .sec_flood_req   (sec_flood_req),
  .sig_sys_err     (sig_sys_err),
  .sec_det_sys_err (sec_det_sys_err),
  .access_lock     (access_lock)
);

// File: tb/test_sync_flood_ctrl.sv
module test_sync_flood_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 2;
  localparam int NS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic local_fatal = 1'b0;
  logic cmd_sys_err_en = 1'b0;
  logic bctl_sys_err_en = 1'b0;
  logic [NP-1:0] pri_flood_seen = '0;
  logic [NS-1:0] sec_flood_seen = '0;
  logic [NP-1:0] pri_flood_req;
  logic [NS-1:0] sec_flood_req;
  logic sig_sys_err, sec_det_sys_err, access_lock;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_flood_ctrl #(.NP(NP), .NS(NS)) i_sync_flood_ctrl (
    .clk(clk), .rst(rst), .local_fatal(local_fatal),
    .cmd_sys_err_en(cmd_sys_err_en), .bctl_sys_err_en(bctl_sys_err_en),
    .pri_flood_seen(pri_flood_seen), .sec_flood_seen(sec_flood_seen),
    .pri_flood_req(pri_flood_req), .sec_flood_req(sec_flood_req),
    .sig_sys_err(sig_sys_err), .sec_det_sys_err(sec_det_sys_err),
    .access_lock(access_lock)
  );

  // {clr, fatal, cmd, bctl, pri_seen[1:0], sec_seen[1:0], exp_pri[1:0], exp_sec[1:0], exp_sig, exp_det}
  localparam int NV = 11;
  localparam logic [13:0] VEC [NV] = '{
    14'b1_1_1_0_00_00_11_11_1_0, // R1 R4 originate
    14'b1_1_0_0_00_00_00_00_0_0, // R2 enable clear
    14'b1_0_0_0_01_00_10_00_0_0, // R3 primary relay
    14'b1_0_0_0_00_10_00_01_0_1, // R3 R5 secondary relay
    14'b1_0_0_1_00_10_11_01_0_1, // R6 bridged up, R4 no sig
    14'b1_0_1_0_10_00_01_00_0_0, // R3 R4 relay with cmd enable set
    14'b1_0_1_1_00_11_11_11_0_1, // R6 R3 both secondary links
    14'b0_0_0_0_00_00_11_11_0_1, // R7 sticky, no new input
    14'b1_0_0_0_11_00_11_00_0_0, // R3 two primary links
    14'b1_0_1_1_00_00_00_00_0_0, // R2 enables alone do nothing
    14'b1_0_0_0_00_01_00_10_0_1  // R5 R6 no bridging when bctl clear
  };

  task automatic check(input string req, input logic [NP-1:0] ep, input logic [NS-1:0] es,
                       input logic esig, input logic edet, input logic elock);
    total++;
    if (pri_flood_req !== ep || sec_flood_req !== es || sig_sys_err !== esig ||
        sec_det_sys_err !== edet || access_lock !== elock) begin
      bad++;
      $display("FAIL %s: got pri=%b sec=%b sig=%b det=%b lock=%b exp pri=%b sec=%b sig=%b det=%b lock=%b",
               req, pri_flood_req, sec_flood_req, sig_sys_err, sec_det_sys_err, access_lock,
               ep, es, esig, edet, elock);
    end
  endtask

  task automatic drive(input logic f, input logic c, input logic b,
                       input logic [NP-1:0] ps, input logic [NS-1:0] ss);
    @(negedge clk);
    rst = 1'b0;
    local_fatal = f; cmd_sys_err_en = c; bctl_sys_err_en = b;
    pri_flood_seen = ps; sec_flood_seen = ss;
    @(posedge clk); #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    local_fatal = 1'b0; cmd_sys_err_en = 1'b0; bctl_sys_err_en = 1'b0;
    pri_flood_seen = '0; sec_flood_seen = '0;
    @(posedge clk); #1;
    check("R8 reset", '0, '0, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hang exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(posedge clk); #1;
    check("R8 initial reset", '0, '0, 1'b0, 1'b0, 1'b0);

    for (int v = 0; v < NV; v++) begin
      logic [13:0] e;
      e = VEC[v];
      if (e[13]) do_reset();
      drive(e[12], e[11], e[10], e[9:8], e[7:6]);
      check($sformatf("vector %0d (R1..R7)", v), e[5:4], e[3:2], e[1], e[0],
            (|e[5:4]) | (|e[3:2]));
    end

    // R2: fatal with enable clear, then enable set later: still nothing
    do_reset();
    drive(1'b1, 1'b0, 1'b0, '0, '0);
    drive(1'b0, 1'b1, 1'b1, '0, '0);
    drive(1'b0, 1'b1, 1'b1, '0, '0);
    check("R2 late enable", '0, '0, 1'b0, 1'b0, 1'b0);

    // R7: originate, then hold idle for several cycles
    do_reset();
    drive(1'b1, 1'b1, 1'b0, '0, '0);
    for (int k = 0; k < 5; k++) drive(1'b0, 1'b0, 1'b0, '0, '0);
    check("R7 sticky originate", '1, '1, 1'b1, 1'b0, 1'b1);

    // R4: relayed flood followed by later origination sets sig only then
    do_reset();
    drive(1'b0, 1'b1, 1'b1, '0, 2'b01);
    check("R4 no sig on bridge", 2'b11, 2'b10, 1'b0, 1'b1, 1'b1);
    drive(1'b1, 1'b1, 1'b1, '0, '0);
    check("R4 sig on originate", 2'b11, 2'b11, 1'b1, 1'b1, 1'b1);

    // R8: reset clears a fully flooded state
    do_reset();
    check("R8 clear after flood", '0, '0, 1'b0, 1'b0, 1'b0);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule